// File: doc/BRIEF.md
# Digital interrupt input noise filter

This block conditions one asynchronous external interrupt pin. The pin first passes through a synchronizer. A prescaled sample strobe then samples it. A run-length filter only accepts a new level after five consecutive samples that all disagree with the level currently held. Edges of the filtered level turn into a single-cycle interrupt request. An edge-select input chooses whether that happens on rising edges, on falling edges or on both.

A small control register sets the sample rate at run time. Two bits choose the system clock divided by 16, 8, 4 or 2. The register can be written as a whole byte or bit by bit through a write mask. When the pin is used as a plain input port, the level output shows the synchronized raw pin instead of the filtered one. The filter runs only from the system clock, so it produces nothing while that clock is stopped.

Top module: `irqnf_top`

## Requirements
- R1: A level lasting four or fewer sample periods never changes the filtered level and never raises a request.
- R2: Control bits 1:0 select the sample period: code 0 gives 16 clocks, 1 gives 8, 2 gives 4 and 3 gives 2. From a pin change to the request there are more than 4 and at most 5 sample periods plus 6 clocks.
- R3: After reset the control register reads 0x00, so sampling is at clock/16. The filtered level and the request are both 0.
- R4: Control read bits 7:2 are always 0. A write only updates the bits whose write-mask bit is 1.
- R5: A level held for five or more sample periods always becomes the filtered level.
- R6: With port_mode=1, pin_level shows the synchronized raw pin. With port_mode=0 it shows the filtered level.
- R7: edge_sel encoding is 0 none, 1 rising, 2 falling, 3 both. Only the selected transitions of the filtered level raise a request.
- R8: irq_req is never high in two consecutive cycles.
- R9: A write that changes the divider code restarts both the prescaler and the run count. Samples taken before the change do not count toward the five.
- R10: A sample equal to the current filtered level clears the run count, so bursts of four differing samples split by one matching sample are never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous interrupt pin |
| port_mode | input | 1 | 1: pin used as plain input, level bypasses filter |
| edge_sel | input | 2 | Request edge select (0 none, 1 rise, 2 fall, 3 both) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_wmask | input | 8 | Per-bit write enable |
| ctl_rdata | output | 8 | Control register read value |
| pin_level | output | 1 | Filtered level, or synchronized raw level in port mode |
| irq_req | output | 1 | One-cycle interrupt request |

## Verification
The bench holds the pin for exact multiples of the sample period, so the number of samples taken is known. It sweeps pulse widths of one to seven samples over every divider and every edge select. A filter that accepted at four samples or needed six would produce a wrong request count. The request latency is measured against a window for each divider, which catches a swapped divider mapping. Bursts of four samples split by one matching sample catch a run counter that is not cleared. Changing the divider partway through a run catches a design that keeps old samples, because such a design would fire far too early.

// File: rtl/irqnf_pkg.sv
package irqnf_pkg;
  typedef enum logic [1:0] {
    EDG_NONE = 2'd0,
    EDG_RISE = 2'd1,
    EDG_FALL = 2'd2,
    EDG_BOTH = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/irqnf_prescaler.sv
module irqnf_prescaler #(
  parameter int PRE_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             restart,
  output logic             smp_en
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  // code 0 is the slowest rate; each step up halves the period
  always_comb lim = PRE_W'((32'd1 << (PRE_W - 32'(div_sel))) - 32'd1);
  assign smp_en = (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (smp_en)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  AST_SMP_SPACED: assert property (@(posedge clk) disable iff (rst) smp_en |=> !smp_en); // R2
endmodule

// File: rtl/irqnf_filter.sv
module irqnf_filter #(
  parameter int RUN_LEN     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  input  logic smp_en,
  input  logic restart,
  output logic sync_lvl,
  output logic filt_lvl
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [RUN_W-1:0]       run_q;
  logic                   lvl_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk)
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= pin_raw;
      end else begin : g_next
        always_ff @(posedge clk)
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (restart) begin
      run_q <= '0;
    end else if (smp_en) begin
      if (sync_lvl == lvl_q) begin
        run_q <= '0;
      end else if (run_q == RUN_W'(RUN_LEN - 1)) begin
        run_q <= '0;
        lvl_q <= sync_lvl;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign filt_lvl = lvl_q;

  AST_RUN_BOUND:     assert property (@(posedge clk) disable iff (rst) run_q < RUN_W'(RUN_LEN)); // R1
  AST_LVL_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst) (lvl_q != $past(lvl_q)) |-> $past(smp_en)); // R1
endmodule

// File: rtl/irqnf_edge.sv
module irqnf_edge
  import irqnf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  edge_sel_e sel,
  output logic      irq
);
  logic lvl_d;
  logic irq_q;
  logic rise, fall;

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      lvl_d <= lvl;
      irq_q <= (rise & sel[0]) | (fall & sel[1]);
    end
  end

  assign irq = irq_q;

  AST_IRQ_SINGLE:   assert property (@(posedge clk) disable iff (rst) irq_q |=> !irq_q); // R8
  AST_IRQ_HAS_EDGE: assert property (@(posedge clk) disable iff (rst) irq_q |-> ($past(lvl) != $past(lvl, 2))); // R7
endmodule

// File: rtl/irqnf_top.sv
module irqnf_top
  import irqnf_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int SEL_W       = 2,
  parameter int PRE_W       = 4,
  parameter int RUN_LEN     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_raw,
  input  logic             port_mode,
  input  logic [1:0]       edge_sel,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic [REG_W-1:0] ctl_wmask,
  output logic [REG_W-1:0] ctl_rdata,
  output logic             pin_level,
  output logic             irq_req
);
  logic [SEL_W-1:0] sel_q, sel_nx;
  logic             div_chg;
  logic             smp_en;
  logic             sync_lvl, filt_lvl;

  always_comb begin
    sel_nx  = (sel_q & ~ctl_wmask[SEL_W-1:0]) | (ctl_wdata[SEL_W-1:0] & ctl_wmask[SEL_W-1:0]);
    div_chg = ctl_wr && (sel_nx != sel_q);
  end

  always_ff @(posedge clk) begin
    if (rst)          sel_q <= '0;
    else if (div_chg) sel_q <= sel_nx;
  end

  assign ctl_rdata = {{(REG_W-SEL_W){1'b0}}, sel_q};

  irqnf_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .div_sel(sel_q), .restart(div_chg), .smp_en(smp_en)
  );

  irqnf_filter #(.RUN_LEN(RUN_LEN), .SYNC_STAGES(SYNC_STAGES)) u_flt (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .smp_en(smp_en), .restart(div_chg),
    .sync_lvl(sync_lvl), .filt_lvl(filt_lvl)
  );

  irqnf_edge u_edg (
    .clk(clk), .rst(rst), .lvl(filt_lvl), .sel(edge_sel_e'(edge_sel)), .irq(irq_req)
  );

  assign pin_level = port_mode ? sync_lvl : filt_lvl;

  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (rst) !$past(ctl_wr) |-> $stable(sel_q)); // R4
endmodule

// File: tb/sim_irqnf_top.sv
module sim_irqnf_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_raw = 1'b0;
  logic       port_mode = 1'b0;
  logic [1:0] edge_sel = 2'd0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'd0;
  logic [7:0] ctl_wmask = 8'd0;
  logic [7:0] ctl_rdata;
  logic       pin_level;
  logic       irq_req;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  int dbl_cnt = 0;
  int cyc = 0;
  int first_irq = -1;
  bit irq_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irqnf_top u0 (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .port_mode(port_mode),
    .edge_sel(edge_sel), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_wmask(ctl_wmask), .ctl_rdata(ctl_rdata), .pin_level(pin_level),
    .irq_req(irq_req)
  );

  always @(negedge clk) begin
    cyc++;
    if (irq_req) begin
      irq_cnt++;
      if (first_irq < 0) first_irq = cyc;
    end
    if (irq_req && irq_prev) dbl_cnt++;
    irq_prev = irq_req;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic [7:0] m);
    ctl_wr = 1'b1; ctl_wdata = d; ctl_wmask = m;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wmask = 8'd0;
  endtask

  function automatic int div_of(input int code);
    return 16 >> code;
  endfunction

  task automatic pulse_run(input int code, input int w, input int es);
    int d = div_of(code);
    int exp;
    edge_sel = 2'(es);
    irq_cnt = 0;
    pin_raw = 1'b1;
    wait_cyc(w * d);
    pin_raw = 1'b0;
    wait_cyc(12 * d + 10);
    if (w < 5) exp = 0;
    else exp = (es == 3) ? 2 : ((es == 0) ? 0 : 1);
    if (w < 5) chk($sformatf("R1 code=%0d w=%0d es=%0d", code, w, es), irq_cnt, exp);
    else       chk($sformatf("R5 R7 code=%0d w=%0d es=%0d", code, w, es), irq_cnt, exp);
  endtask

  task automatic latency(input int code, input string req);
    int d = div_of(code);
    int start, lat, ok;
    edge_sel = 2'd1;
    first_irq = -1;
    start = cyc;
    pin_raw = 1'b1;
    wait_cyc(5 * d + 10);
    lat = (first_irq < 0) ? -1 : first_irq - start;
    ok = (lat > 4 * d && lat <= 5 * d + 6) ? 1 : 0;
    if (!ok) begin
      checks++; fails++;
      $display("FAIL %s code=%0d latency actual=%0d expected=(%0d,%0d]", req, code, lat, 4 * d, 5 * d + 6);
    end else checks++;
    pin_raw = 1'b0;
    wait_cyc(6 * d + 10);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    // R3 reset state
    chk("R3 rdata", ctl_rdata, 0);
    chk("R3 level", pin_level, 0);
    chk("R3 irq", irq_req, 0);
    latency(0, "R3 default divider");

    // R4 masked byte/bit writes, high bits read zero
    wr(8'hFF, 8'h01);
    chk("R4 bit0 write", ctl_rdata, 8'h01);
    wr(8'h00, 8'h02);
    chk("R4 masked-off bit", ctl_rdata, 8'h01);
    wr(8'hFF, 8'h02);
    chk("R4 bit1 write", ctl_rdata, 8'h03);
    wr(8'hFC, 8'hFF);
    chk("R4 upper bits zero", ctl_rdata, 8'h00);

    // R2 divider mapping by latency window
    for (int c = 0; c < 4; c++) begin
      wr(8'(c), 8'hFF);
      latency(c, "R2");
    end

    // R1 R5 R7 sweep over divider, width, edge select
    for (int c = 0; c < 4; c++) begin
      wr(8'(c), 8'hFF);
      for (int w = 1; w <= 7; w++)
        for (int e = 0; e < 4; e++)
          if (e != 0 || w == 6) pulse_run(c, w, e);
    end

    // R10 bursts of four split by one matching sample
    wr(8'h03, 8'hFF);
    edge_sel = 2'd3;
    irq_cnt = 0;
    for (int k = 0; k < 10; k++) begin
      pin_raw = 1'b1; wait_cyc(4 * 2);
      pin_raw = 1'b0; wait_cyc(1 * 2);
    end
    wait_cyc(20);
    chk("R10 split bursts", irq_cnt, 0);
    chk("R10 level", pin_level, 0);

    // R9 divider change restarts run count
    edge_sel = 2'd1;
    wait_cyc(20);
    irq_cnt = 0;
    pin_raw = 1'b1;
    wait_cyc(8);
    wr(8'h00, 8'hFF);
    wait_cyc(60);
    chk("R9 no early accept", irq_cnt, 0);
    wait_cyc(60);
    chk("R9 accept at new rate", irq_cnt, 1);
    pin_raw = 1'b0;
    wait_cyc(16 * 7);

    // R6 port mode bypass
    port_mode = 1'b0;
    pin_raw = 1'b1;
    wait_cyc(3);
    chk("R6 filtered level", pin_level, 0);
    port_mode = 1'b1;
    #1;
    chk("R6 raw level", pin_level, 1);
    pin_raw = 1'b0;
    wait_cyc(3);
    chk("R6 raw low", pin_level, 0);
    port_mode = 1'b0;
    wait_cyc(16 * 7);

    chk("R8 single-cycle request", dbl_cnt, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule